// File: doc/BRIEF.md
# Statically Routed Mesh Switch with Two-Entry Hop Queues

This block is one switch of a word-level mesh for a spatial accelerator. It has four neighbour directions (north, south, east, west) plus a local port, and each direction carries `LINKS` parallel links. Every output link takes its word from one input link. That choice is held in a configuration register that is written before the run and left alone while the application executes. Nothing is arbitrated at run time. An input that is picked by several outputs broadcasts each word to all of them.

Each output link has its own two-entry queue and a valid/ready handshake, so backpressure travels one hop at a time. The ready returned upstream depends only on registered queue occupancy and configuration. A stall therefore becomes visible upstream one cycle after the queue fills, and the second queue slot catches the word that was already in flight during that cycle.

Link numbering is `dir*LINKS + link`, with directions N=0, S=1, E=2, W=3 and local=4. The same numbering applies to inputs, outputs and the configuration fields. Data for link k sits in bits `[k*DATA_W +: DATA_W]` of the packed data buses.

Top module: `sw_static_switch`

## Requirements
- R1: A word accepted on input s (in_valid_i[s] and in_ready_o[s] both high at a clock edge) appears on every output configured to s starting the next cycle. Words from one input leave in arrival order, and each is presented until out_ready_i is high at an edge.
- R2: A configuration write (cfg_we_i high at an edge) sets output cfg_port_i to take input cfg_src_i when cfg_en_i is 1, or to have no source when cfg_en_i is 0. The new route applies from the next cycle, and routes change only through this port.
- R3: Each output queue holds at most two words. The routed input sees ready high while the queue holds fewer than two words and low when it holds two, so no word is lost or overwritten.
- R4: in_ready_o depends only on registered queue occupancy and configuration. Raising out_ready_i on a full queue does not raise in_ready_o until the following cycle.
- R5: An input routed to several outputs is ready only when every one of those queues has room. Each accepted word is delivered exactly once to each of them.
- R6: An output with no configured source keeps out_valid_o low.
- R7: While rst_ni is low all queues are emptied and out_valid_o is all zero. The configuration survives reset.
- R8: An input that no output selects keeps in_ready_o low.
- R9: A stalled output stalls only the input routed to it. Routes that do not use that output keep moving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_port_i | input | SEL_W | Output link being configured |
| cfg_src_i | input | SEL_W | Input link to route to it |
| cfg_en_i | input | 1 | 1 connects the route, 0 leaves the output unsourced |
| in_data_i | input | NPORT*DATA_W | Input link words, packed |
| in_valid_i | input | NPORT | Input link valid |
| in_ready_o | output | NPORT | Input link ready |
| out_data_o | output | NPORT*DATA_W | Output link words, packed |
| out_valid_o | output | NPORT | Output link valid |
| out_ready_i | input | NPORT | Output link ready |

## Verification
A table of single-route transfers covers every direction, several link indices and the local port. Each entry confirms that the word reaches only the configured output, exactly once. A stall pattern fills one queue while a second route runs next to it. This separates correct two-slot capture and registered ready from loss or overwrite, and shows that blocking stays on the stalled output. A broadcast pattern with one destination stalled exposes duplicate or missing copies. A reset with data in flight, followed by traffic with no reconfiguration, separates clearing of the queues from clearing of the routes.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int NUM_DIRS = 5;
  typedef enum logic [2:0] {
    DIR_N = 3'd0,
    DIR_S = 3'd1,
    DIR_E = 3'd2,
    DIR_W = 3'd3,
    DIR_L = 3'd4
  } dir_e;
endpackage

// File: rtl/sw_route_cfg.sv
module sw_route_cfg #(
  parameter int NPORT = 10,
  parameter int SEL_W = 4
) (
  input  logic                            clk_i,
  input  logic                            we_i,
  input  logic [SEL_W-1:0]                port_i,
  input  logic [SEL_W-1:0]                src_i,
  input  logic                            en_i,
  output logic [NPORT-1:0]                en_q_o,
  output logic [NPORT-1:0][SEL_W-1:0]     src_q_o
);
  // no reset: routes survive rst_ni
  for (genvar p = 0; p < NPORT; p++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && (port_i == SEL_W'(p))) begin
        en_q_o[p]  <= en_i;
        src_q_o[p] <= src_i;
      end
    end
  end
endmodule

// File: rtl/sw_fanout.sv
module sw_fanout #(
  parameter int NPORT = 10,
  parameter int SEL_W = 4,
  parameter int DW    = 16
) (
  input  logic [NPORT-1:0]            cfg_en_i,
  input  logic [NPORT-1:0][SEL_W-1:0] cfg_src_i,
  input  logic [NPORT-1:0]            can_accept_i,
  input  logic [NPORT*DW-1:0]         in_data_i,
  input  logic [NPORT-1:0]            in_valid_i,
  output logic [NPORT-1:0]            in_ready_o,
  output logic [NPORT-1:0]            push_o,
  output logic [NPORT*DW-1:0]         wdata_o
);
  logic [NPORT-1:0][NPORT-1:0] sel;     // sel[out][in]
  logic [NPORT-1:0][NPORT-1:0] dst_of;  // dst_of[in][out]

  for (genvar j = 0; j < NPORT; j++) begin : g_out
    for (genvar i = 0; i < NPORT; i++) begin : g_in
      assign sel[j][i]    = cfg_en_i[j] && (cfg_src_i[j] == SEL_W'(i));
      assign dst_of[i][j] = sel[j][i];
    end
    assign push_o[j] = |(sel[j] & in_valid_i & in_ready_o);
  end

  // broadcast advances only when every destination has room
  for (genvar i = 0; i < NPORT; i++) begin : g_rdy
    assign in_ready_o[i] = (|dst_of[i]) && (&(~dst_of[i] | can_accept_i));
  end

  always_comb begin
    wdata_o = '0;
    for (int j = 0; j < NPORT; j++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (sel[j][i]) wdata_o[j*DW +: DW] = wdata_o[j*DW +: DW] | in_data_i[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/sw_skid_q.sv
module sw_skid_q #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ready_i,
  output logic          can_accept_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [1:0]    cnt_o
);
  logic [DW-1:0] mem [2];
  logic          wr_ptr, rd_ptr;
  logic [1:0]    cnt;
  logic          do_push, do_pop;

  assign valid_o      = (cnt != 2'd0);
  assign can_accept_o = (cnt != 2'd2);
  assign do_push      = push_i && can_accept_o;
  assign do_pop       = valid_o && ready_i;
  assign data_o       = mem[rd_ptr];
  assign cnt_o        = cnt;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= 1'b0;
      rd_ptr <= 1'b0;
      cnt    <= 2'd0;
    end else begin
      if (do_push) wr_ptr <= ~wr_ptr;
      if (do_pop)  rd_ptr <= ~rd_ptr;
      cnt <= cnt + {1'b0, do_push} - {1'b0, do_pop};
    end
  end
endmodule

// File: rtl/sw_static_switch.sv
module sw_static_switch #(
  parameter  int LINKS  = 2,
  parameter  int DATA_W = 16,
  localparam int NPORT  = sw_pkg::NUM_DIRS * LINKS,
  localparam int SEL_W  = $clog2(NPORT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [SEL_W-1:0]        cfg_port_i,
  input  logic [SEL_W-1:0]        cfg_src_i,
  input  logic                    cfg_en_i,
  input  logic [NPORT*DATA_W-1:0] in_data_i,
  input  logic [NPORT-1:0]        in_valid_i,
  output logic [NPORT-1:0]        in_ready_o,
  output logic [NPORT*DATA_W-1:0] out_data_o,
  output logic [NPORT-1:0]        out_valid_o,
  input  logic [NPORT-1:0]        out_ready_i
);
  logic [NPORT-1:0]             cfg_en_q;
  logic [NPORT-1:0][SEL_W-1:0]  cfg_src_q;
  logic [NPORT-1:0]             can_accept;
  logic [NPORT-1:0]             push;
  logic [NPORT*DATA_W-1:0]      wdata;
  logic [NPORT*2-1:0]           q_cnt;

  sw_route_cfg #(.NPORT(NPORT), .SEL_W(SEL_W)) u_cfg (
    .clk_i   (clk_i),
    .we_i    (cfg_we_i),
    .port_i  (cfg_port_i),
    .src_i   (cfg_src_i),
    .en_i    (cfg_en_i),
    .en_q_o  (cfg_en_q),
    .src_q_o (cfg_src_q)
  );

  sw_fanout #(.NPORT(NPORT), .SEL_W(SEL_W), .DW(DATA_W)) u_fan (
    .cfg_en_i     (cfg_en_q),
    .cfg_src_i    (cfg_src_q),
    .can_accept_i (can_accept),
    .in_data_i    (in_data_i),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .push_o       (push),
    .wdata_o      (wdata)
  );

  for (genvar j = 0; j < NPORT; j++) begin : g_q
    sw_skid_q #(.DW(DATA_W)) u_q (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_i       (push[j]),
      .wdata_i      (wdata[j*DATA_W +: DATA_W]),
      .ready_i      (out_ready_i[j]),
      .can_accept_o (can_accept[j]),
      .valid_o      (out_valid_o[j]),
      .data_o       (out_data_o[j*DATA_W +: DATA_W]),
      .cnt_o        (q_cnt[j*2 +: 2])
    );
  end
endmodule

// File: rtl/sw_static_switch_chk.sv
module sw_static_switch_chk #(
  parameter int NPORT = 10,
  parameter int SEL_W = 4,
  parameter int DW    = 16
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NPORT-1:0]                in_ready_o,
  input logic [NPORT*DW-1:0]             out_data_o,
  input logic [NPORT-1:0]                out_valid_o,
  input logic [NPORT-1:0]                out_ready_i,
  input logic [NPORT-1:0]                cfg_en_q,
  input logic [NPORT-1:0][SEL_W-1:0]     cfg_src_q,
  input logic [NPORT*2-1:0]              q_cnt
);
  logic [NPORT-1:0] has_dest;
  logic [NPORT-1:0] dest_full;

  always_comb begin
    has_dest  = '0;
    dest_full = '0;
    for (int j = 0; j < NPORT; j++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (cfg_en_q[j] && cfg_src_q[j] == SEL_W'(i)) begin
          has_dest[i] = 1'b1;
          if (q_cnt[j*2 +: 2] == 2'd2) dest_full[i] = 1'b1;
        end
      end
    end
  end

  // R7
  always @(posedge clk_i) begin
    if (!rst_ni) reset_idle_chk: assert (out_valid_o == '0);
  end

  for (genvar j = 0; j < NPORT; j++) begin : g_o
    // R1
    out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] && !out_ready_i[j] |=> out_valid_o[j] && $stable(out_data_o[j*DW +: DW]));
    // R6
    idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_q[j] && !out_valid_o[j] |=> !out_valid_o[j]);
    // R3
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_cnt[j*2 +: 2] <= 2'd2);
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    // R8
    no_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !has_dest[i] |-> !in_ready_o[i]);
    // R5
    full_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dest_full[i] |-> !in_ready_o[i]);
  end
endmodule

bind sw_static_switch sw_static_switch_chk #(.NPORT(NPORT), .SEL_W(SEL_W), .DW(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .cfg_en_q    (cfg_en_q),
  .cfg_src_q   (cfg_src_q),
  .q_cnt       (q_cnt)
);

// File: tb/sw_static_switch_tb.sv
module sw_static_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINKS = 2;
  localparam int DW    = 16;
  localparam int NP    = 5 * LINKS;
  localparam int SW    = $clog2(NP);
  localparam int NVEC  = 8;
  // {src, dst, data}
  localparam logic [23:0] VEC [NVEC] = '{
    {4'd0, 4'd1, 16'hA001}, {4'd2, 4'd5, 16'hB012},
    {4'd3, 4'd8, 16'hC0DE}, {4'd9, 4'd0, 16'h1234},
    {4'd7, 4'd6, 16'hFFFF}, {4'd4, 4'd9, 16'h0001},
    {4'd8, 4'd8, 16'h5A5A}, {4'd1, 4'd3, 16'h8000}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              cfg_we = 1'b0;
  logic [SW-1:0]     cfg_port = '0;
  logic [SW-1:0]     cfg_src = '0;
  logic              cfg_en = 1'b0;
  logic [NP*DW-1:0]  in_data = '0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP-1:0]     in_ready;
  logic [NP*DW-1:0]  out_data;
  logic [NP-1:0]     out_valid;
  logic [NP-1:0]     out_ready = '1;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_static_switch #(.LINKS(LINKS), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_port_i(cfg_port),
    .cfg_src_i(cfg_src), .cfg_en_i(cfg_en), .in_data_i(in_data),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .out_data_o(out_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int port, input int src, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_port = SW'(port); cfg_src = SW'(src); cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [DW-1:0] od(input int j);
    return out_data[j*DW +: DW];
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 reset clears valid", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    for (int p = 0; p < NP; p++) cfg_write(p, 0, 1'b0);
    @(negedge clk);
    check("R8 no route no ready", 32'(in_ready), 32'h0);
    check("R6 unrouted outputs idle", 32'(out_valid), 32'h0);

    // table walk: single routes (R1, R2, R6)
    for (int v = 0; v < NVEC; v++) begin
      int s, d;
      s = int'(VEC[v][23:20]);
      d = int'(VEC[v][19:16]);
      cfg_write(d, s, 1'b1);
      @(negedge clk);
      in_valid[s] = 1'b1;
      in_data[s*DW +: DW] = VEC[v][15:0];
      check("R2 route live after write", 32'(in_ready[s]), 32'h1);
      @(negedge clk);
      in_valid[s] = 1'b0;
      check("R1 word delivered", {15'h0, out_valid[d], od(d)}, {15'h0, 1'b1, VEC[v][15:0]});
      check("R6 only routed output valid", 32'(out_valid & ~(NP'(1) << d)), 32'h0);
      @(negedge clk);
      check("R1 delivered once", 32'(out_valid[d]), 32'h0);
      cfg_write(d, s, 1'b0);
    end

    // stall: R3, R4, R9
    cfg_write(3, 5, 1'b1);
    cfg_write(7, 2, 1'b1);
    out_ready[3] = 1'b0;
    @(negedge clk);
    in_valid[5] = 1'b1; in_data[5*DW +: DW] = 16'h0011;
    check("R3 ready empty", 32'(in_ready[5]), 32'h1);
    @(negedge clk);
    in_data[5*DW +: DW] = 16'h0022;
    check("R3 ready one held", 32'(in_ready[5]), 32'h1);
    @(negedge clk);
    in_data[5*DW +: DW] = 16'h0033;
    check("R3 full drops ready", 32'(in_ready[5]), 32'h0);
    in_valid[2] = 1'b1; in_data[2*DW +: DW] = 16'h0077;
    check("R9 other route ready", 32'(in_ready[2]), 32'h1);
    @(negedge clk);
    in_valid[2] = 1'b0;
    check("R9 other route delivered", {15'h0, out_valid[7], od(7)}, {15'h0, 1'b1, 16'h0077});
    check("R3 head held", 32'(od(3)), 32'h0011);
    out_ready[3] = 1'b1;
    #1;
    check("R4 ready registered", 32'(in_ready[5]), 32'h0);
    @(negedge clk);
    check("R3 second word kept", 32'(od(3)), 32'h0022);
    check("R4 ready next cycle", 32'(in_ready[5]), 32'h1);
    @(negedge clk);
    in_valid[5] = 1'b0;
    check("R3 third word order", 32'(od(3)), 32'h0033);
    @(negedge clk);
    check("R3 drained", 32'(out_valid[3]), 32'h0);
    cfg_write(3, 5, 1'b0);
    cfg_write(7, 2, 1'b0);

    // broadcast: R5
    cfg_write(0, 9, 1'b1);
    cfg_write(6, 9, 1'b1);
    out_ready[6] = 1'b0;
    @(negedge clk);
    in_valid[9] = 1'b1; in_data[9*DW +: DW] = 16'h0100;
    check("R5 bcast ready", 32'(in_ready[9]), 32'h1);
    @(negedge clk);
    in_data[9*DW +: DW] = 16'h0200;
    check("R5 bcast ready one slot", 32'(in_ready[9]), 32'h1);
    check("R5 free dest first", 32'(od(0)), 32'h0100);
    @(negedge clk);
    in_data[9*DW +: DW] = 16'h0300;
    check("R5 stalled dest blocks", 32'(in_ready[9]), 32'h0);
    check("R5 free dest second", 32'(od(0)), 32'h0200);
    @(negedge clk);
    check("R5 no duplicate", 32'(out_valid[0]), 32'h0);
    out_ready[6] = 1'b1;
    @(negedge clk);
    check("R5 resume", 32'(in_ready[9]), 32'h1);
    check("R5 stalled dest order", 32'(od(6)), 32'h0200);
    @(negedge clk);
    in_valid[9] = 1'b0;
    check("R5 both get third", {od(0), od(6)}, {16'h0300, 16'h0300});
    @(negedge clk);
    check("R5 both drained", 32'(out_valid), 32'h0);

    // reset with data in flight, config retained: R7
    out_ready = '0;
    @(negedge clk);
    in_valid[9] = 1'b1; in_data[9*DW +: DW] = 16'h0400;
    @(negedge clk);
    in_valid[9] = 1'b0;
    check("R7 data held pre reset", 32'(out_valid), 32'h41);
    #1 rst_n = 1'b0;
    #1;
    check("R7 reset empties queues", 32'(out_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = '1;
    @(negedge clk);
    in_valid[9] = 1'b1; in_data[9*DW +: DW] = 16'h0500;
    check("R7 config kept", 32'(in_ready[9]), 32'h1);
    @(negedge clk);
    in_valid[9] = 1'b0;
    check("R7 route survives reset", {od(0), od(6)}, {16'h0500, 16'h0500});

    // reroute: R2, R8
    cfg_write(0, 4, 1'b1);
    cfg_write(6, 9, 1'b0);
    @(negedge clk);
    check("R8 orphan input not ready", 32'(in_ready[9]), 32'h0);
    in_valid[4] = 1'b1; in_data[4*DW +: DW] = 16'h0600;
    @(negedge clk);
    in_valid[4] = 1'b0;
    check("R2 new source used", {15'h0, out_valid[0], od(0)}, {15'h0, 1'b1, 16'h0600});
    check("R6 disabled output idle", 32'(out_valid[6]), 32'h0);
    @(negedge clk);
    finish_run();
  end
endmodule